// File: doc/BRIEF.md
# Memory-mapped 32 kHz sync counter

This peripheral keeps a free-running count of rising edges of a slow reference clock, nominally 32.768 kHz, and lets software read it over a simple single-cycle register bus. The reference arrives asynchronously. It passes through a two-flop synchronizer and an edge detector in the bus clock domain, so each rising reference edge advances the count exactly once. The count is zero after reset and wraps silently. A fixed identification register sits next to the count register.

The bus carries one request per cycle and returns one response in the following cycle. Full-width and half-width reads are supported. Software without full-width loads reads the lower half of the count first. That read captures the upper half into a holding register, and a later read of the upper half returns the captured value. The two halves therefore come from the same instant. Writes, byte accesses and undecoded offsets are answered normally with an error pulse attached.

The data width `DATA_W` (default 32) is also the count width. A half is `DATA_W/2` bits wide. Offsets are byte addresses of `ADDR_W` bits (default 8).

Top module: `sync_tick_counter`

## Requirements
- R1: After reset the count is zero, the holding register is zero and `rsp_valid_o`, `rsp_err_o` and `rsp_rdata_o` are all low.
- R2: Each rising edge of `ref_tick_i` adds exactly one to the count, three bus clock rising edges after the reference rises. A falling reference edge adds nothing.
- R3: The count wraps from all ones to zero without any flag or error.
- R4: A full-width read (`req_size_i` = 2) of offset 0x00 returns the identification value 0x21 with no error.
- R5: A full-width read of offset 0x10 returns the count as it stood on the clock edge that accepted the request, with no error.
- R6: A half-width read (`req_size_i` = 1) with address bit 1 clear returns the low half of the register at that offset, zero-extended. It also stores that register's upper half in the holding register.
- R7: A half-width read with address bit 1 set returns the holding register, zero-extended, with no error, at any offset. The holding register is left unchanged.
- R8: A byte-size (`req_size_i` = 0) or reserved-size (`req_size_i` = 3) read is a width error: it returns zero with the error pulse and changes neither the count nor the holding register.
- R9: Any write is acknowledged with `rsp_valid_o`, zero data and the error pulse, and changes no state.
- R10: A full-width read, or a half-width read with address bit 1 clear, at any offset other than 0x00 and 0x10 returns zero with the error pulse. In the half-width case the holding register becomes zero.
- R11: Every request accepted on a rising edge gets exactly one single-cycle response on the next edge. `rsp_err_o` is high only together with `rsp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | Asynchronous slow reference clock to be counted |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | Request is a write (always rejected) |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_size_i | input | 2 | Access size: 0 byte, 1 half, 2 full, 3 reserved |
| rsp_valid_o | output | 1 | Read data valid or write acknowledge, one cycle after the request |
| rsp_rdata_o | output | DATA_W | Read data, zero on errors and writes |
| rsp_err_o | output | 1 | Error pulse that comes with the response |

## Verification
A request driven on a falling edge is accepted on the next rising edge. Its response is registered on that same edge and sampled on the following falling edge. The bench checks once more one cycle later that the response has gone low. A reference rise reaches the count on the third rising edge of the bus clock. The bench therefore holds each reference pulse high for three cycles and low for three more before reading, so every read sees a settled count equal to the number of pulses sent, modulo the counter range. Checks on the holding register always read it back through an upper-half read placed after the access that could have disturbed it.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam logic [7:0] IDENT_VALUE = 8'h21;
    localparam int unsigned IDENT_OFS  = 'h00;
    localparam int unsigned COUNT_OFS  = 'h10;

endpackage

// File: rtl/tick_sync.sv
module tick_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_state_t;

    sync_state_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = ref_i;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise_o = sync_q.stable & ~sync_q.prev;

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i) begin
            cnt_d.count = cnt_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.count;

endmodule

// File: rtl/reg_port.sv
module reg_port
    import sync_cnt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    input  logic [DATA_W-1:0] count_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              rsp_err_o,
    output logic [DATA_W/2-1:0] hold_o
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] IDENT_W   = DATA_W'(IDENT_VALUE);
    localparam logic [ADDR_W-1:0] IDENT_A   = ADDR_W'(IDENT_OFS);
    localparam logic [ADDR_W-1:0] COUNT_A   = ADDR_W'(COUNT_OFS);

    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
        logic [HALF_W-1:0] hold;
    } port_state_t;

    port_state_t port_d, port_q;

    logic              dec_hit;
    logic [DATA_W-1:0] dec_data;

    always_comb begin
        dec_hit  = 1'b0;
        dec_data = '0;
        if (req_addr_i == IDENT_A) begin
            dec_hit  = 1'b1;
            dec_data = IDENT_W;
        end else if (req_addr_i == COUNT_A) begin
            dec_hit  = 1'b1;
            dec_data = count_i;
        end
    end

    always_comb begin
        port_d           = port_q;
        port_d.rsp_valid = 1'b0;
        port_d.rsp_err   = 1'b0;
        port_d.rsp_rdata = '0;
        if (req_valid_i) begin
            port_d.rsp_valid = 1'b1;
            if (req_write_i) begin
                port_d.rsp_err = 1'b1;
            end else begin
                case (acc_size_e'(req_size_i))
                    SZ_WORD: begin
                        port_d.rsp_rdata = dec_data;
                        port_d.rsp_err   = ~dec_hit;
                    end
                    SZ_HALF: begin
                        if (req_addr_i[1]) begin
                            port_d.rsp_rdata = DATA_W'(port_q.hold);
                        end else begin
                            port_d.rsp_rdata = DATA_W'(dec_data[HALF_W-1:0]);
                            port_d.hold      = dec_data[DATA_W-1:HALF_W];
                            port_d.rsp_err   = ~dec_hit;
                        end
                    end
                    default: begin
                        port_d.rsp_err = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign rsp_valid_o = port_q.rsp_valid;
    assign rsp_rdata_o = port_q.rsp_rdata;
    assign rsp_err_o   = port_q.rsp_err;
    assign hold_o      = port_q.hold;

endmodule

// File: rtl/sync_tick_counter.sv
module sync_tick_counter #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ref_tick_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_size_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              rsp_err_o
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic              tick_rise;
    logic [DATA_W-1:0] cnt_value;
    logic [HALF_W-1:0] hold_value;

    tick_sync u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ref_i  (ref_tick_i),
        .rise_o (tick_rise)
    );

    tick_counter #(
        .CNT_W (DATA_W)
    ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (tick_rise),
        .count_o (cnt_value)
    );

    reg_port #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_port (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_size_i  (req_size_i),
        .count_i     (cnt_value),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o),
        .rsp_err_o   (rsp_err_o),
        .hold_o      (hold_value)
    );

endmodule

// File: rtl/sync_tick_counter_chk.sv
module sync_tick_counter_chk
    import sync_cnt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W/2-1:0] hold
);
    logic rd_word, rd_half_lo, rd_bad_size;
    assign rd_word     = req_valid && !req_write && (req_size == SZ_WORD);
    assign rd_half_lo  = req_valid && !req_write && (req_size == SZ_HALF) && !req_addr[1];
    assign rd_bad_size = req_valid && !req_write && ((req_size == SZ_BYTE) || (req_size == SZ_RSVD));

    a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r11_err_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    a_r9_write_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_err && rsp_rdata == '0));

    a_r8_width_error: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bad_size |=> (rsp_err && rsp_rdata == '0));

    a_r4_ident_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && req_addr == ADDR_W'(IDENT_OFS)) |=> (!rsp_err && rsp_rdata == DATA_W'(IDENT_VALUE)));

    a_r5_count_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && req_addr == ADDR_W'(COUNT_OFS)) |=> (!rsp_err && rsp_rdata == $past(count)));

    a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + DATA_W'(1)));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_half_lo |=> $stable(hold));

endmodule

bind sync_tick_counter sync_tick_counter_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .req_valid (req_valid_i),
    .req_write (req_write_i),
    .req_addr  (req_addr_i),
    .req_size  (req_size_i),
    .rsp_valid (rsp_valid_o),
    .rsp_rdata (rsp_rdata_o),
    .rsp_err   (rsp_err_o),
    .count     (cnt_value),
    .hold      (hold_value)
);

// File: tb/sync_tick_counter_tb_top.sv
module sync_tick_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 12;
    localparam int AW    = 5;
    localparam int HW    = DW / 2;
    localparam int CMOD  = 1 << DW;
    localparam int LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_err;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;
    int exp_hold = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_tick_counter #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .ref_tick_i (ref_tick),
        .req_valid_i (req_valid), .req_write_i (req_write),
        .req_addr_i (req_addr), .req_size_i (req_size),
        .rsp_valid_o (rsp_valid), .rsp_rdata_o (rsp_rdata), .rsp_err_o (rsp_err)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        ref_tick = 1'b1;
        repeat (3) @(negedge clk);
        ref_tick = 1'b0;
        repeat (3) @(negedge clk);
        exp_cnt = (exp_cnt + 1) % CMOD;
    endtask

    // Drive at a falling edge, sample the response on the next falling edge.
    task automatic access(input bit wr, input int addr, input int sz,
                          output int v, output int d, output int e);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        req_size  = 2'(sz);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        v = int'(rsp_valid);
        d = int'(rsp_rdata);
        e = int'(rsp_err);
    endtask

    task automatic expect_rsp(input string req, input bit wr, input int addr,
                              input int sz, input int ed, input int ee);
        int v, d, e;
        access(wr, addr, sz, v, d, e);
        chk({req, " valid"}, v, 1);
        chk({req, " data"}, d, ed);
        chk({req, " err"}, e, ee);
    endtask

    function automatic int word_of(input int addr);
        if (addr == 'h00) return 'h21;
        if (addr == 'h10) return exp_cnt;
        return 0;
    endfunction

    function automatic int hit_of(input int addr);
        return (addr == 'h00 || addr == 'h10) ? 1 : 0;
    endfunction

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 rsp_valid idle", int'(rsp_valid), 0);
        chk("R1 rsp_err idle", int'(rsp_err), 0);
        chk("R1 rdata idle", int'(rsp_rdata), 0);
        expect_rsp("R1 count zero", 0, 'h10, 2, 0, 0);
        expect_rsp("R1 hold zero", 0, 'h12, 1, 0, 0);

        // R4: identification value
        expect_rsp("R4 ident", 0, 'h00, 2, 'h21, 0);

        // R11: response lasts one cycle only
        begin
            int v, d, e;
            access(0, 'h40 % (1 << AW) + 'h04, 2, v, d, e);
            chk("R11 bad read valid", v, 1);
            chk("R11 bad read err", e, 1);
            @(negedge clk);
            chk("R11 valid single cycle", int'(rsp_valid), 0);
            chk("R11 err single cycle", int'(rsp_err), 0);
        end

        // R2, R5: one count per reference pulse
        for (int k = 0; k < 100; k++) begin
            tick();
            expect_rsp("R2 R5 count after pulse", 0, 'h10, 2, exp_cnt, 0);
        end

        // R2: ref held high for a long time counts once
        ref_tick = 1'b1;
        repeat (20) @(negedge clk);
        ref_tick = 1'b0;
        repeat (4) @(negedge clk);
        exp_cnt = (exp_cnt + 1) % CMOD;
        expect_rsp("R2 long pulse counts once", 0, 'h10, 2, exp_cnt, 0);

        // R6, R7: split read of the count with halves captured together
        for (int k = 0; k < 40; k++) tick();
        expect_rsp("R6 low half", 0, 'h10, 1, exp_cnt % (1 << HW), 0);
        exp_hold = exp_cnt >> HW;
        for (int k = 0; k < 70; k++) tick();
        expect_rsp("R7 held upper at 0x12", 0, 'h12, 1, exp_hold, 0);
        expect_rsp("R7 held upper at 0x02", 0, 'h02, 1, exp_hold, 0);
        expect_rsp("R7 held upper at 0x1E", 0, 'h1E, 1, exp_hold, 0);
        expect_rsp("R7 hold unchanged by reads", 0, 'h16, 1, exp_hold, 0);

        // R8: width errors leave state alone
        expect_rsp("R8 byte read", 0, 'h10, 0, 0, 1);
        expect_rsp("R8 byte read lower", 0, 'h00, 0, 0, 1);
        expect_rsp("R8 reserved size", 0, 'h10, 3, 0, 1);
        expect_rsp("R8 hold kept", 0, 'h12, 1, exp_hold, 0);
        expect_rsp("R8 count kept", 0, 'h10, 2, exp_cnt, 0);

        // R9: writes rejected, no state change
        for (int a = 0; a < 32; a += 2) begin
            for (int s = 0; s < 4; s++) begin
                expect_rsp("R9 write", 1, a, s, 0, 1);
            end
        end
        expect_rsp("R9 hold kept", 0, 'h12, 1, exp_hold, 0);
        expect_rsp("R9 count kept", 0, 'h10, 2, exp_cnt, 0);

        // R4, R5, R10: full-width sweep over every offset
        for (int a = 0; a < 32; a++) begin
            expect_rsp("R10 word sweep", 0, a, 2, word_of(a), 1 - hit_of(a));
        end

        // R6, R10: low-half sweep, each followed by an upper-half readback
        for (int a = 0; a < 32; a++) begin
            if ((a & 2) == 0) begin
                expect_rsp("R6 R10 low half sweep", 0, a, 1, word_of(a) % (1 << HW), 1 - hit_of(a));
                exp_hold = word_of(a) >> HW;
                expect_rsp("R6 R10 hold after low", 0, a | 2, 1, exp_hold, 0);
            end
        end

        // R3: wrap from all ones to zero
        while (exp_cnt != CMOD - 1) tick();
        expect_rsp("R3 count at max", 0, 'h10, 2, CMOD - 1, 0);
        tick();
        expect_rsp("R3 wrapped to zero", 0, 'h10, 2, 0, 0);
        tick();
        expect_rsp("R3 counting after wrap", 0, 'h10, 2, 1, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule